// File: doc/BRIEF.md
# Edge-Detecting General-Purpose Pin Controller

This block controls 28 general-purpose pins through a small 32-bit register bus. Software chooses a direction for each pin. It drives output pins by writing ones to a set register or a clear register, so it never needs a read-modify-write sequence. It can read the level of every pin at any time. Each pin input passes through a two-stage synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier.

Rising and falling edges have separate per-pin enables. Enabling both makes a pin report either edge. An enabled edge latches into a status register, and software clears a status bit by writing a one to it. Pins 0 to 10 each drive their own interrupt line. The status bits of pins 11 to 27 are ORed into one shared line. A further 28-bit register only stores a value and has no effect on the pins.

Top module: `pio_edge_ctrl`

## Requirements
- R1: After reset the direction, output latch, rising-enable, falling-enable and status registers are zero, every pin is an input (pin_oe = 0), and all interrupt outputs are low.
- R2: The register at byte offset 0x04 holds the directions. Bit i = 1 makes pin i an output (pin_oe[i] = 1), and 0 makes it an input. The register reads back what was written.
- R3: Writing a 1 to bit i at offset 0x08 sets pin_out[i] high on the next clock. Writing a 1 to bit i at offset 0x0C drives it low. Zero bits leave the latch unchanged. Both offsets read as zero.
- R4: Offset 0x00 returns the level of all 28 pins, whatever their direction, two clocks after a pin changes. Writes to it have no effect.
- R5: When bit i of the rising-enable register (offset 0x10) is set, a 0-to-1 transition of pin i sets status bit i three clocks after the pin changes. Edges on pins whose enable is clear set nothing.
- R6: Bit i of the falling-enable register (offset 0x14) does the same for 1-to-0 transitions. With both enables set, either transition is reported.
- R7: Status (offset 0x18) is write-one-to-clear. A written 1 clears that bit, a written 0 leaves it, and a set bit stays set until it is cleared.
- R8: If an enabled edge on pin i is detected on the same clock as a write that clears status bit i, the bit stays set.
- R9: irq_pin[i] equals status bit i for pins 0 to 10. irq_shared is high while any of status bits 11 to 27 is set.
- R10: Bits 31 to 28 of every register read as zero, and writing ones to them has no effect. Accesses with bus_addr[1:0] not equal to zero are ignored and read as zero.
- R11: Offset 0x1C stores a 28-bit value that reads back unchanged and has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 28 | Pad levels, asynchronous to clk |
| pin_out | output | 28 | Output latch |
| pin_oe | output | 28 | Output enable, 1 = pin driven |
| irq_pin | output | 11 | Per-pin interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Shared interrupt for pins 11 to 27 |

## Verification
A wrong status bit shows at the interrupt outputs on the clock after it is latched. For pins 11 to 27 it shows only as the OR on the shared line, so the bench also reads the status register. A lost or extra edge shows three clocks after the pin change. A slip in the synchroniser moves that point by a cycle, and the bench samples the exact cycle to catch it. The R8 collision is tested by lining a clear write up with the one cycle in which the edge is detected. A fault in the output latch shows on pin_out on the clock after the write. Because the pads loop back, it also shows in the level register two clocks after that.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int BUS_AW = 5;
  localparam int BUS_DW = 32;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_ALT   = 3'd7
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [BUS_AW-1:0] addr);
    return reg_sel_e'(addr[4:2]);
  endfunction

  function automatic logic word_aligned(input logic [BUS_AW-1:0] addr);
    return addr[1:0] == 2'b00;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

endmodule

// File: rtl/pio_edge_unit.sv
module pio_edge_unit #(
  parameter int NPINS = 28,
  parameter int NLOW  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] cur,
  input  logic [NPINS-1:0] prev,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] status_q,
  output logic [NPINS-1:0] edge_hit,
  output logic [NLOW-1:0]  irq_low,
  output logic             irq_high
);

  localparam int NHIGH = NPINS - NLOW;

  function automatic logic [NPINS-1:0] detect(
    input logic [NPINS-1:0] p, c, re, fe);
    return (~p & c & re) | (p & ~c & fe);
  endfunction

  function automatic logic [NPINS-1:0] next_status(
    input logic [NPINS-1:0] old, clr, hit);
    return (old & ~clr) | hit;
  endfunction

  logic [NPINS-1:0] clr_eff;

  assign edge_hit = detect(prev, cur, rise_en, fall_en);
  assign clr_eff  = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_status(status_q, clr_eff, edge_hit);
  end

  for (genvar i = 0; i < NLOW; i++) begin : g_low_irq
    assign irq_low[i] = status_q[i];
  end

  logic [NHIGH-1:0] high_bits;
  assign high_bits = status_q[NPINS-1:NLOW];
  assign irq_high  = |high_bits;

  // R8: an edge in the clearing cycle must leave its bit set
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  // R5: a status bit rises only because of a detected edge
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(edge_hit)) == '0));

  // R7: set bits stay until a write-one clear
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_eff) & ~status_q) == '0));

  // R9: the shared line rises only after an edge on a high pin
  assert_shared_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_high) |-> $past(|edge_hit[NPINS-1:NLOW]));

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int NPINS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [NPINS-1:0]  level,
  input  logic [NPINS-1:0]  status,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  rise_q,
  output logic [NPINS-1:0]  fall_q,
  output logic              stat_clr_we,
  output logic [NPINS-1:0]  stat_clr_mask
);

  localparam int PAD = BUS_DW - NPINS;

  function automatic logic [NPINS-1:0] latch_next(
    input logic [NPINS-1:0] old, s, c);
    return (old | s) & ~c;
  endfunction

  reg_sel_e         sel;
  logic             ok;
  logic [NPINS-1:0] wmask;
  logic             wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_alt;
  logic [NPINS-1:0] alt_q;
  logic [NPINS-1:0] rd_val;
  logic             unused_wdata_hi;

  assign sel    = decode_sel(bus_addr);
  assign ok     = word_aligned(bus_addr);
  assign wmask  = bus_wdata[NPINS-1:0];
  assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:NPINS];

  assign wr_dir  = bus_wr && ok && sel == REG_DIR;
  assign wr_set  = bus_wr && ok && sel == REG_SET;
  assign wr_clr  = bus_wr && ok && sel == REG_CLR;
  assign wr_rise = bus_wr && ok && sel == REG_RISE;
  assign wr_fall = bus_wr && ok && sel == REG_FALL;
  assign wr_alt  = bus_wr && ok && sel == REG_ALT;

  assign stat_clr_we   = bus_wr && ok && sel == REG_STAT;
  assign stat_clr_mask = wmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wmask;
      if (wr_rise) rise_q <= wmask;
      if (wr_fall) fall_q <= wmask;
      if (wr_alt)  alt_q  <= wmask;
      if (wr_set || wr_clr)
        out_q <= latch_next(out_q, wr_set ? wmask : '0, wr_clr ? wmask : '0);
    end
  end

  always_comb begin
    rd_val = '0;
    if (ok) begin
      unique case (sel)
        REG_LEVEL: rd_val = level;
        REG_DIR:   rd_val = dir_q;
        REG_SET:   rd_val = '0;
        REG_CLR:   rd_val = '0;
        REG_RISE:  rd_val = rise_q;
        REG_FALL:  rd_val = fall_q;
        REG_STAT:  rd_val = status;
        REG_ALT:   rd_val = alt_q;
        default:   rd_val = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD{1'b0}}, rd_val};

  // R3: a set write forces the written bits high
  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wmask)) == $past(wmask)));

  // R3: a clear write forces the written bits low
  assert_clr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wmask)) == '0));

  // R3: without a set or clear write the latch holds
  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(out_q));

  // R2: direction changes only on its own write
  assert_dir_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/pio_edge_ctrl.sv
module pio_edge_ctrl
  import pio_pkg::*;
#(
  parameter int NPINS = 28,
  parameter int NLOW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NLOW-1:0]   irq_pin,
  output logic              irq_shared
);

  logic [NPINS-1:0] sync_lvl, prev_lvl;
  logic [NPINS-1:0] dir_q, out_q, rise_q, fall_q;
  logic [NPINS-1:0] status_q, edge_hit, clr_mask;
  logic             clr_we;

  pio_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_q   (sync_lvl),
    .prev_q   (prev_lvl)
  );

  pio_regfile #(.NPINS(NPINS)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .level         (sync_lvl),
    .status        (status_q),
    .bus_rdata     (bus_rdata),
    .dir_q         (dir_q),
    .out_q         (out_q),
    .rise_q        (rise_q),
    .fall_q        (fall_q),
    .stat_clr_we   (clr_we),
    .stat_clr_mask (clr_mask)
  );

  pio_edge_unit #(.NPINS(NPINS), .NLOW(NLOW)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (sync_lvl),
    .prev     (prev_lvl),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .status_q (status_q),
    .edge_hit (edge_hit),
    .irq_low  (irq_pin),
    .irq_high (irq_shared)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R10: the unused upper read bits stay zero
  assert_rdata_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_DW-1:NPINS] == '0);

endmodule

// File: tb/pio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module pio_edge_ctrl_tb;

  localparam int NP = 28;
  localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08,
    A_CLR = 5'h0C, A_RISE = 5'h10, A_FALL = 5'h14, A_STAT = 5'h18, A_ALT = 5'h1C;

  // {from, to, rise_en, fall_en, expected status}
  localparam logic [139:0] VEC [8] = '{
    {28'h0000000, 28'h0000001, 28'hFFFFFFF, 28'h0000000, 28'h0000001},
    {28'h0000001, 28'h0000000, 28'hFFFFFFF, 28'h0000000, 28'h0000000},
    {28'h0000001, 28'h0000000, 28'h0000000, 28'hFFFFFFF, 28'h0000001},
    {28'h0000000, 28'hFFFFFFF, 28'h00000FF, 28'hFFFFFFF, 28'h00000FF},
    {28'hFFFFFFF, 28'h0000000, 28'h0000000, 28'hF000000, 28'hF000000},
    {28'h5555555, 28'hAAAAAAA, 28'hFFFFFFF, 28'h0000000, 28'hAAAAAAA},
    {28'h5555555, 28'hAAAAAAA, 28'h0000000, 28'hFFFFFFF, 28'h5555555},
    {28'h0F0F0F0, 28'h00FF000, 28'h0FFFFFF, 28'h0FFFFFF, 28'h0FF00F0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] ext = '0, pin_in, pin_out, pin_oe;
  logic [10:0] irq_pin;
  logic irq_shared;
  int errors = 0, checks = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_shared(irq_shared)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; write is taken at the next rising edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [NP-1:0] lvl_exp;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    bus_read(A_DIR, rd);  check("R1 dir", rd, 0);
    bus_read(A_RISE, rd); check("R1 rise", rd, 0);
    bus_read(A_FALL, rd); check("R1 fall", rd, 0);
    bus_read(A_STAT, rd); check("R1 status", rd, 0);
    check("R1 pin_oe", 32'(pin_oe), 0);
    check("R1 pin_out", 32'(pin_out), 0);
    check("R1 irqs", {20'd0, irq_shared, irq_pin}, 0);
    @(negedge clk);

    // R5 R6 R9 vector table
    for (int v = 0; v < 8; v++) begin
      logic [27:0] f, t, re, fe, ex;
      {f, t, re, fe, ex} = VEC[v];
      bus_write(A_RISE, 0);
      bus_write(A_FALL, 0);
      ext = f;
      idle(4);
      bus_write(A_STAT, 32'hFFFFFFFF);
      bus_write(A_RISE, 32'(re));
      bus_write(A_FALL, 32'(fe));
      ext = t;
      idle(4);
      bus_read(A_STAT, rd);
      check("R5/R6 table status", rd, 32'(ex));
      check("R9 table irq_pin", 32'(irq_pin), 32'(ex[10:0]));
      check("R9 table irq_shared", 32'(irq_shared), 32'(|ex[27:11]));
      @(negedge clk);
    end
    bus_write(A_RISE, 0);
    bus_write(A_FALL, 0);
    bus_write(A_STAT, 32'hFFFFFFFF);

    // R2 direction
    bus_write(A_DIR, 32'h0000F0F);
    check("R2 pin_oe", 32'(pin_oe), 32'h0000F0F);
    bus_read(A_DIR, rd); check("R2 readback", rd, 32'h0000F0F);
    @(negedge clk);

    // R3 set / clear
    bus_write(A_SET, 32'h00000FF);
    check("R3 set", 32'(pin_out), 32'h00000FF);
    bus_write(A_CLR, 32'h000000F);
    check("R3 clear", 32'(pin_out), 32'h00000F0);
    bus_write(A_SET, 0);
    bus_write(A_CLR, 0);
    check("R3 zero writes", 32'(pin_out), 32'h00000F0);
    bus_read(A_SET, rd); check("R3 set reads zero", rd, 0);
    bus_read(A_CLR, rd); check("R3 clear reads zero", rd, 0);
    @(negedge clk);

    // R4 level with mixed directions, then ignored write
    ext = 28'hABCDE5A;
    idle(3);
    lvl_exp = (28'h0000F0F & 28'h00000F0) | (~28'h0000F0F & 28'hABCDE5A);
    bus_read(A_LVL, rd); check("R4 level", rd, 32'(lvl_exp));
    @(negedge clk);
    bus_write(A_LVL, 32'h0000000);
    bus_read(A_LVL, rd); check("R4 write ignored", rd, 32'(lvl_exp));
    @(negedge clk);

    // R10 upper bits and misaligned access
    bus_write(A_DIR, 32'hFFFFFFFF);
    bus_read(A_DIR, rd); check("R10 upper bits", rd, 32'h0FFFFFFF);
    @(negedge clk);
    bus_write(5'h05, 32'h0);
    bus_read(A_DIR, rd); check("R10 misaligned write", rd, 32'h0FFFFFFF);
    bus_read(5'h05, rd); check("R10 misaligned read", rd, 0);
    @(negedge clk);
    bus_write(A_DIR, 0);

    // R11 alternate-function storage
    bus_write(A_ALT, 32'hF1234567);
    bus_read(A_ALT, rd); check("R11 readback", rd, 32'h01234567);
    check("R11 no pin effect", 32'(pin_oe), 0);
    @(negedge clk);

    // R7 write-one-to-clear
    ext = '0;
    idle(4);
    bus_write(A_STAT, 32'hFFFFFFFF);
    bus_write(A_RISE, 32'h0000003);
    ext = 28'h0000003;
    idle(4);
    bus_write(A_STAT, 0);
    bus_read(A_STAT, rd); check("R7 zero write", rd, 3);
    @(negedge clk);
    bus_write(A_STAT, 1);
    bus_read(A_STAT, rd); check("R7 partial clear", rd, 2);
    @(negedge clk);
    bus_write(A_STAT, 32'hFFFFFFFF);

    // R8 edge in the same cycle as its clear
    bus_write(A_RISE, 32'h0000008);
    bus_write(A_FALL, 32'h0000008);
    ext = 28'h000000B;
    idle(4);
    bus_read(A_STAT, rd); check("R5 bit3 rise", rd, 8);
    @(negedge clk);
    ext = 28'h0000003;
    idle(2);
    bus_write(A_STAT, 8);
    bus_read(A_STAT, rd); check("R8 edge wins", rd, 8);
    @(negedge clk);
    bus_write(A_STAT, 8);
    bus_read(A_STAT, rd); check("R7 clear after", rd, 0);
    @(negedge clk);

    // R9 boundary pins 10 and 11
    bus_write(A_RISE, 32'h0000C00);
    ext = 28'h0000403;
    idle(4);
    check("R9 pin10 line", 32'(irq_pin), 32'h400);
    check("R9 shared low", 32'(irq_shared), 0);
    ext = 28'h0000C03;
    idle(4);
    check("R9 shared high", 32'(irq_shared), 1);
    bus_write(A_STAT, 32'h0000800);
    check("R9 shared cleared", 32'(irq_shared), 0);
    check("R9 pin10 kept", 32'(irq_pin), 32'h400);

    finish_run();
  end

endmodule